// File: doc/BRIEF.md
# Multi-Cycle Bit Scan Unit

This unit searches a 32-bit operand for a set bit and reports its position. In the forward direction it returns the position of the least significant set bit. In the reverse direction it returns the position of the most significant set bit. It does not use a single-cycle priority encoder. Instead it walks the operand in three nested stages: first across bytes, then across the nibbles of the chosen byte, then across the bits of the chosen nibble. Each stage spends a fixed number of clocks per step, so the latency depends on the data and follows a closed formula.

A caller raises `scan_start` for one cycle with the operand and direction present. The unit captures both, holds `scan_busy` high while it searches, and pulses `scan_done` for one cycle when the result is ready. An all-zero operand takes a short fixed path and raises `scan_zero`. In that case the index output keeps its previous value. Any start request made while a scan is in progress is dropped.

Top module: `bscan_unit`

## Requirements
- R1: In the forward direction (`scan_rev`=0), a non-zero operand produces `scan_idx` equal to the position (0 = LSB) of its lowest set bit, with `scan_zero`=0.
- R2: In the reverse direction (`scan_rev`=1), a non-zero operand produces `scan_idx` equal to the position of its highest set bit, with `scan_zero`=0.
- R3: Let p be the lowest set position, with b = p/8, i = (p mod 8)/4 and n = p mod 4. Counting the start cycle as clock 1, a forward scan of a non-zero operand raises `scan_done` in clock 8 + 4(b+1) + 3(i+1) + 3(n+1).
- R4: Let q be 31 minus the highest set position, with b, i and n taken from q in the same way. A reverse scan of a non-zero operand raises `scan_done` in clock 9 + 4(b+1) + 3(i+1) + 3(n+1).
- R5: A zero operand raises `scan_done` in clock 6 (forward) or clock 7 (reverse). It sets `scan_zero`=1, and `scan_idx` keeps the value it had before the scan.
- R6: `scan_done` is high for exactly one cycle per accepted start. `scan_busy` is high from the cycle after the start cycle through the done cycle, and low in the cycle after done.
- R7: A `scan_start` pulse while `scan_busy` is high is ignored. This includes a pulse in the done cycle. It produces no extra done pulse, does not alter the running result and does not keep `scan_busy` high.
- R8: The operand and direction are captured in the start cycle. Changes to `scan_opnd` or `scan_rev` during a scan do not affect its index, zero flag or latency.
- R9: After reset, `scan_busy`, `scan_done` and `scan_zero` are 0 and `scan_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | One-cycle request to begin a scan |
| scan_rev | input | 1 | 0 = find lowest set bit, 1 = find highest set bit |
| scan_opnd | input | 32 | Operand to search |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle result strobe |
| scan_idx | output | 5 | Position of the found bit |
| scan_zero | output | 1 | Operand was all zeros |

## Verification
The bench measures the latency of every scan to the exact clock. It covers the extremes of the formula: bit 0 and bit 31 in each direction, which give the shortest and longest searches. An off-by-one in any stage's step count, or in the fixed overhead, shows up there as a wrong cycle count. Zero operands in both directions check the short path and confirm that the index holds; a design that cleared the index or ran the full walk would be reported. Two further cases target input handling. A second start during a scan, or in its done cycle, would cause a restart or a stray done pulse in a faulty design. Inputs scrambled after the start cycle expose a design that reads the live operand instead of a captured copy.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_BYTE = 3'd2,
    PH_NIB  = 3'd3,
    PH_BIT  = 3'd4
  } phase_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bscan_capture.sv
module bscan_capture #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             rev_in,
  input  logic [WIDTH-1:0] opnd_in,
  output logic [WIDTH-1:0] data_q,
  output logic             rev_q,
  output logic             zero_q
);

  logic [WIDTH-1:0] flipped;

  // Mirror the operand so that a reverse scan becomes a forward scan.
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_mirror
      assign flipped[g] = opnd_in[WIDTH-1-g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      rev_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (load) begin
      data_q <= rev_in ? flipped : opnd_in;
      rev_q  <= rev_in;
      zero_q <= ~|opnd_in;
    end
  end

endmodule

// File: rtl/bscan_slice.sv
module bscan_slice #(
  parameter int WIDTH  = 32,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  localparam int NBYTE  = WIDTH / BYTE_W,
  localparam int NPB    = BYTE_W / NIB_W,
  localparam int NNIB   = WIDTH / NIB_W,
  localparam int BSEL_W = (NBYTE > 1) ? $clog2(NBYTE) : 1,
  localparam int NSEL_W = (NPB > 1) ? $clog2(NPB) : 1,
  localparam int TSEL_W = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
  input  logic [WIDTH-1:0]  data,
  input  logic [BSEL_W-1:0] bsel,
  input  logic [NSEL_W-1:0] nsel,
  input  logic [TSEL_W-1:0] tsel,
  output logic              byte_hit,
  output logic              nib_hit,
  output logic              bit_hit
);

  logic [NBYTE-1:0] byte_or;
  logic [NIB_W-1:0] nibs [NNIB];
  logic [NIB_W-1:0] cur_nib;
  logic [BSEL_W+NSEL_W-1:0] nib_ix;

  genvar gb, gn;
  generate
    for (gb = 0; gb < NBYTE; gb++) begin : g_byte
      assign byte_or[gb] = |data[gb*BYTE_W +: BYTE_W];
      for (gn = 0; gn < NPB; gn++) begin : g_nib
        assign nibs[gb*NPB + gn] = data[gb*BYTE_W + gn*NIB_W +: NIB_W];
      end
    end
  endgenerate

  assign nib_ix   = {bsel, nsel};
  assign cur_nib  = nibs[nib_ix];
  assign byte_hit = byte_or[bsel];
  assign nib_hit  = |cur_nib;
  assign bit_hit  = cur_nib[tsel];

endmodule

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
#(
  parameter int NBYTE    = 4,
  parameter int NPB      = 2,
  parameter int NIB_W    = 4,
  parameter int BYTE_CLK = 4,
  parameter int NIB_CLK  = 3,
  parameter int BIT_CLK  = 3,
  parameter int PRE_FWD  = 8,
  parameter int PRE_REV  = 9,
  parameter int ZERO_FWD = 6,
  parameter int ZERO_REV = 7,
  localparam int BSEL_W = (NBYTE > 1) ? $clog2(NBYTE) : 1,
  localparam int NSEL_W = (NPB > 1) ? $clog2(NPB) : 1,
  localparam int TSEL_W = (NIB_W > 1) ? $clog2(NIB_W) : 1,
  localparam int MAXLD  = max2(max2(PRE_REV, PRE_FWD), max2(BYTE_CLK, max2(NIB_CLK, BIT_CLK))),
  localparam int TK_W   = $clog2(MAXLD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rev_in,
  input  logic              opnd_zero,
  input  logic              cap_zero,
  input  logic              byte_hit,
  input  logic              nib_hit,
  input  logic              bit_hit,
  output logic              load,
  output logic [BSEL_W-1:0] bsel,
  output logic [NSEL_W-1:0] nsel,
  output logic [TSEL_W-1:0] tsel,
  output logic              fin_next,
  output logic              busy_q,
  output logic              done_q
);

  // Each phase and step lasts at least two clocks, so the final cycle is
  // announced one cycle ahead from a tick value of one.
  phase_t           phase, phase_d;
  logic [TK_W-1:0]  tk, tk_d;
  logic [BSEL_W-1:0] bsel_d;
  logic [NSEL_W-1:0] nsel_d;
  logic [TSEL_W-1:0] tsel_d;
  int unsigned       pre_len;

  assign load = (phase == PH_IDLE) && start;

  always_comb begin
    if (opnd_zero) pre_len = rev_in ? ZERO_REV - 1 : ZERO_FWD - 1;
    else           pre_len = rev_in ? PRE_REV - 1  : PRE_FWD - 1;
  end

  always_comb begin
    phase_d = phase;
    tk_d    = tk;
    bsel_d  = bsel;
    nsel_d  = nsel;
    tsel_d  = tsel;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_PRE;
          tk_d    = TK_W'(pre_len - 1);
          bsel_d  = '0;
          nsel_d  = '0;
          tsel_d  = '0;
        end
      end
      PH_PRE: begin
        if (tk != '0)    tk_d = tk - 1'b1;
        else if (cap_zero) phase_d = PH_IDLE;
        else begin
          phase_d = PH_BYTE;
          tk_d    = TK_W'(BYTE_CLK - 1);
        end
      end
      PH_BYTE: begin
        if (tk != '0) tk_d = tk - 1'b1;
        else if (byte_hit) begin
          phase_d = PH_NIB;
          tk_d    = TK_W'(NIB_CLK - 1);
          nsel_d  = '0;
        end else begin
          bsel_d = bsel + 1'b1;
          tk_d   = TK_W'(BYTE_CLK - 1);
        end
      end
      PH_NIB: begin
        if (tk != '0) tk_d = tk - 1'b1;
        else if (nib_hit) begin
          phase_d = PH_BIT;
          tk_d    = TK_W'(BIT_CLK - 1);
          tsel_d  = '0;
        end else begin
          nsel_d = nsel + 1'b1;
          tk_d   = TK_W'(NIB_CLK - 1);
        end
      end
      PH_BIT: begin
        if (tk != '0) tk_d = tk - 1'b1;
        else if (bit_hit) phase_d = PH_IDLE;
        else begin
          tsel_d = tsel + 1'b1;
          tk_d   = TK_W'(BIT_CLK - 1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign fin_next = (tk == TK_W'(1)) &&
                    (((phase == PH_PRE) && cap_zero) ||
                     ((phase == PH_BIT) && bit_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      tk     <= '0;
      bsel   <= '0;
      nsel   <= '0;
      tsel   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      phase  <= phase_d;
      tk     <= tk_d;
      bsel   <= bsel_d;
      nsel   <= nsel_d;
      tsel   <= tsel_d;
      busy_q <= (phase_d != PH_IDLE);
      done_q <= fin_next;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R6
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> busy_q);

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(done_q));

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> (phase != PH_PRE) || ($past(phase) == PH_PRE));

endmodule

// File: rtl/bscan_unit.sv
module bscan_unit
  import bscan_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int BYTE_W   = 8,
  parameter int NIB_W    = 4,
  parameter int BYTE_CLK = 4,
  parameter int NIB_CLK  = 3,
  parameter int BIT_CLK  = 3,
  parameter int PRE_FWD  = 8,
  parameter int PRE_REV  = 9,
  parameter int ZERO_FWD = 6,
  parameter int ZERO_REV = 7,
  localparam int IDX_W  = $clog2(WIDTH),
  localparam int NBYTE  = WIDTH / BYTE_W,
  localparam int NPB    = BYTE_W / NIB_W,
  localparam int BSEL_W = (NBYTE > 1) ? $clog2(NBYTE) : 1,
  localparam int NSEL_W = (NPB > 1) ? $clog2(NPB) : 1,
  localparam int TSEL_W = (NIB_W > 1) ? $clog2(NIB_W) : 1,
  localparam int MAXL   = max2(PRE_REV, PRE_FWD) + BYTE_CLK*NBYTE + NIB_CLK*NPB + BIT_CLK*NIB_W,
  localparam int CNT_W  = $clog2(MAXL + 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_start,
  input  logic             scan_rev,
  input  logic [WIDTH-1:0] scan_opnd,
  output logic             scan_busy,
  output logic             scan_done,
  output logic [IDX_W-1:0] scan_idx,
  output logic             scan_zero
);

  logic [WIDTH-1:0]  cap_data;
  logic              cap_rev, cap_zero, load, fin_next;
  logic              byte_hit, nib_hit, bit_hit;
  logic [BSEL_W-1:0] bsel;
  logic [NSEL_W-1:0] nsel;
  logic [TSEL_W-1:0] tsel;
  logic [IDX_W-1:0]  pos;

  bscan_capture #(.WIDTH(WIDTH)) cap_i (
    .clk(clk), .rst(rst), .load(load), .rev_in(scan_rev), .opnd_in(scan_opnd),
    .data_q(cap_data), .rev_q(cap_rev), .zero_q(cap_zero)
  );

  bscan_slice #(.WIDTH(WIDTH), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) slice_i (
    .data(cap_data), .bsel(bsel), .nsel(nsel), .tsel(tsel),
    .byte_hit(byte_hit), .nib_hit(nib_hit), .bit_hit(bit_hit)
  );

  bscan_ctrl #(
    .NBYTE(NBYTE), .NPB(NPB), .NIB_W(NIB_W),
    .BYTE_CLK(BYTE_CLK), .NIB_CLK(NIB_CLK), .BIT_CLK(BIT_CLK),
    .PRE_FWD(PRE_FWD), .PRE_REV(PRE_REV), .ZERO_FWD(ZERO_FWD), .ZERO_REV(ZERO_REV)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start(scan_start), .rev_in(scan_rev),
    .opnd_zero(~|scan_opnd), .cap_zero(cap_zero),
    .byte_hit(byte_hit), .nib_hit(nib_hit), .bit_hit(bit_hit),
    .load(load), .bsel(bsel), .nsel(nsel), .tsel(tsel),
    .fin_next(fin_next), .busy_q(scan_busy), .done_q(scan_done)
  );

  // Position within the (possibly mirrored) captured word.
  assign pos = IDX_W'({bsel, nsel, tsel});

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_idx  <= '0;
      scan_zero <= 1'b0;
    end else if (fin_next) begin
      scan_zero <= cap_zero;
      if (!cap_zero)
        scan_idx <= cap_rev ? IDX_W'(WIDTH - 1) - pos : pos;
    end
  end

  // Busy-cycle counter guarding the latency ceiling.
  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !scan_busy) busy_cnt <= '0;
    else                   busy_cnt <= busy_cnt + 1'b1;
  end

  // R3
  lat_max_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (busy_cnt <= CNT_W'(MAXL - 2)));

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_done && scan_zero) |-> $stable(scan_idx));

  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_busy && !scan_done) |=> ($stable(cap_data) && $stable(cap_rev)));

endmodule

// File: tb/bscan_unit_tb.sv
module bscan_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_start = 1'b0;
  logic        scan_rev = 1'b0;
  logic [31:0] scan_opnd = '0;
  logic        scan_busy, scan_done, scan_zero;
  logic [4:0]  scan_idx;

  always #4 clk = ~clk;  // 125 MHz

  bscan_unit dut_i (
    .clk(clk), .rst(rst), .scan_start(scan_start), .scan_rev(scan_rev),
    .scan_opnd(scan_opnd), .scan_busy(scan_busy), .scan_done(scan_done),
    .scan_idx(scan_idx), .scan_zero(scan_zero)
  );

  typedef struct {
    int  idx;
    bit  zero;
    int  lat;
    int  t0;
    bit  rev;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   last_idx = 0;
  bit   idle_next = 1'b0;
  bit   busy_gap = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Independent model built from the requirements.
  task automatic model(input logic [31:0] op, input bit rev, output exp_t e);
    int p, b, i, n;
    p = -1;
    if (op == 0) begin
      e.zero = 1; e.idx = last_idx; e.lat = rev ? 7 : 6;
    end else begin
      if (!rev) begin
        for (int k = 31; k >= 0; k--) if (op[k]) p = k;
        e.idx = p; b = p / 8; i = (p % 8) / 4; n = p % 4;
      end else begin
        for (int k = 0; k < 32; k++) if (op[k]) p = k;
        e.idx = p; b = (31 - p) / 8; i = ((31 - p) % 8) / 4; n = (31 - p) % 4;
      end
      e.zero = 0;
      e.lat = (rev ? 9 : 8) + 4*(b+1) + 3*(i+1) + 3*(n+1);
      last_idx = e.idx;
    end
    e.rev = rev;
  endtask

  // Driver: scramble selects whether inputs change after the start cycle (R8).
  task automatic run_scan(input logic [31:0] op, input bit rev, input bit scramble);
    exp_t e;
    while (scan_busy) @(negedge clk);
    model(op, rev, e);
    e.t0 = cyc;
    q.push_back(e);
    scan_opnd  = op;
    scan_rev   = rev;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    if (scramble) begin
      while (q.size() != 0) begin
        scan_opnd = $urandom;
        scan_rev  = ~scan_rev;
        @(negedge clk);
      end
    end else begin
      while (q.size() != 0) @(negedge clk);
    end
    @(negedge clk);
  endtask

  // Monitor: compares results as they appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (idle_next) begin
        check(!scan_busy && !scan_done, "R6 busy/done low after done", int'(scan_busy), 0);
        idle_next = 1'b0;
      end
      if (q.size() != 0 && cyc > q[0].t0 && !scan_busy && !scan_done) busy_gap = 1'b1;
      if (scan_done) begin
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(scan_zero == e.zero, e.zero ? "R5 zero flag" : "R1/R2 zero flag clear",
                int'(scan_zero), int'(e.zero));
          check(int'(scan_idx) == e.idx,
                e.zero ? "R5 index hold" : (e.rev ? "R2 reverse index" : "R1 forward index"),
                int'(scan_idx), e.idx);
          check((cyc - e.t0 + 1) == e.lat,
                e.zero ? "R5 zero latency" : (e.rev ? "R4 reverse latency" : "R3 forward latency"),
                cyc - e.t0 + 1, e.lat);
          check(!busy_gap, "R6 busy held through scan", int'(busy_gap), 0);
          busy_gap  = 1'b0;
          idle_next = 1'b1;
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(scan_busy == 0, "R9 busy after reset", int'(scan_busy), 0);
    check(scan_done == 0, "R9 done after reset", int'(scan_done), 0);
    check(scan_zero == 0, "R9 zero after reset", int'(scan_zero), 0);
    check(scan_idx == 0, "R9 index after reset", int'(scan_idx), 0);

    // R3/R1 shortest and longest forward
    run_scan(32'h0000_0001, 0, 0);
    run_scan(32'h8000_0000, 0, 0);
    // R4/R2 longest and shortest reverse
    run_scan(32'h0000_0001, 1, 0);
    run_scan(32'h8000_0000, 1, 0);
    run_scan(32'h0F0F_0000, 0, 0);
    run_scan(32'h0F0F_0000, 1, 0);
    // R5 zero in both directions, index holds
    run_scan(32'h0001_0000, 0, 0);
    run_scan(32'h0, 0, 0);
    run_scan(32'h0, 1, 0);
    run_scan(32'hFFFF_FFFF, 1, 0);
    run_scan(32'h0, 0, 0);

    // R8 inputs scrambled after start
    run_scan(32'h0000_0400, 0, 1);
    run_scan(32'h0020_0000, 1, 1);
    run_scan(32'h0, 0, 1);

    // R7 start during a scan and in its done cycle
    begin
      exp_t e;
      model(32'h0001_0000, 0, e);
      e.t0 = cyc;
      q.push_back(e);
      scan_opnd = 32'h0001_0000; scan_rev = 0; scan_start = 1;
      @(negedge clk);
      scan_start = 0;
      repeat (5) @(negedge clk);
      scan_opnd = 32'h0000_0002; scan_rev = 1; scan_start = 1;
      @(negedge clk);
      scan_start = 0;
      while (!scan_done) @(negedge clk);
      scan_start = 1;  // sampled at the edge ending the done cycle
      @(negedge clk);
      scan_start = 0;
      check(!scan_busy, "R7 start in done cycle ignored", int'(scan_busy), 0);
      repeat (60) @(negedge clk);
      check(!scan_busy && q.size() == 0, "R7 no extra scan", int'(scan_busy), 0);
    end

    // R1/R2/R3/R4 spread of positions
    for (int k = 0; k < 64; k++) begin
      logic [31:0] v;
      v = $urandom & $urandom & $urandom;
      if (k % 8 == 0) v = 32'h1 << (k / 2);
      run_scan(v, k[0], k % 5 == 0);
    end

    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule